// File: doc/BRIEF.md
# Pipeline Register File with Write-Through Bypass

This block holds the 32 general-purpose registers of a five-stage integer pipeline. Each register is 32 bits wide. The decode stage uses two read ports to fetch both source operands in the same cycle. The write-back stage uses one write port to retire a result. The reads are combinational. The write is committed on the rising clock edge.

Write-back and decode often touch the same register in the same clock cycle. When they do, the read port returns the value being written in that cycle, not the older stored value. This has the same effect as writing in the first half of the cycle and reading in the second half. The hazard is therefore resolved in hardware, and the pipeline does not stall for it.

Register 0 is hard-wired to zero: it always reads zero, writes to it are discarded, and it is never bypassed. An active-low asynchronous reset clears every register to zero.

Top module: `rfb_regfile`

## Requirements
- R1: While reset is low, and after it is released, every register reads as zero on both ports until a write changes it.
- R2: When `wr_en` is 1 and `wr_addr` is not 0, `wr_data` is stored in register `wr_addr` at the rising clock edge. Later reads of that address return it.
- R3: When `wr_en` is 0, a clock edge changes no register.
- R4: When `wr_en` is 1 and a read address equals a non-zero `wr_addr`, that read port returns `wr_data` in the same cycle, before the edge.
- R5: When `wr_en` is 0, a read address equal to `wr_addr` still returns the stored value and not `wr_data`.
- R6: Address 0 always reads as zero. A write to address 0 has no effect, and a read of address 0 is never bypassed, even while a write to address 0 is enabled.
- R7: The two read ports work independently. They may read the same or different registers, and both may be bypassed in the same cycle.
- R8: In a load-then-use sequence, a load writes register 8 in write-back while an add three instructions later reads register 8 in decode in the same cycle. The add sees the loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all registers |
| rd_addr_a | input | 5 | Register index for read port A |
| rd_addr_b | input | 5 | Register index for read port B |
| wr_addr | input | 5 | Register index for the write port |
| wr_data | input | 32 | Data to be written |
| wr_en | input | 1 | Write enable |
| rd_data_a | output | 32 | Read data for port A |
| rd_data_b | output | 32 | Read data for port B |

## Verification
The first pattern reads every register right after reset. This separates a cleared array from one that holds stale values. Directed writes followed by reads with write enable low show whether data is committed on the edge or only forwarded. A read that collides with a write while write enable is low shows whether the bypass is wrongly taken.

Same-cycle collisions on one port, on both ports at once, and on address 0 tell a correct bypass apart from a missing one and from a bypass that wrongly fires for register 0. A load-then-use sequence on register 8 and a long random run over a narrow address range, which makes collisions common, are compared cycle by cycle against a behavioural model.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    // Default geometry of the integer register file.
    localparam int unsigned RFB_DATA_W   = 32;
    localparam int unsigned RFB_ADDR_W   = 5;

    // The pipeline needs two source operands per decoded instruction.
    localparam int unsigned RFB_RD_PORTS = 2;

    // Index of the constant-zero register.
    localparam int unsigned RFB_ZERO_IDX = 0;

endpackage

// File: rtl/rfb_storage.sv
module rfb_storage
    import rfb_pkg::*;
#(
    parameter int unsigned DATA_W = RFB_DATA_W,
    parameter int unsigned ADDR_W = RFB_ADDR_W,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DEPTH-1:0][DATA_W-1:0]  q
);

    // One block per entry; entry zero is a constant and has no flops.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        if (g == RFB_ZERO_IDX) begin : g_zero
            assign q[g] = '0;
        end else begin : g_live
            logic              sel;
            logic [DATA_W-1:0] entry_q;

            assign sel = wr_en && (wr_addr == ADDR_W'(g));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    entry_q <= '0;
                end else if (sel) begin
                    entry_q <= wr_data;
                end
            end

            assign q[g] = entry_q;
        end
    end

    // R2: an enabled write to a live entry is visible in that entry next cycle
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0) |=> (q[$past(wr_addr)] == $past(wr_data)));

    // R3: no enabled write leaves the whole array unchanged
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(q));

    // R6: a write aimed at entry zero changes nothing
    p_zero_write_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> $stable(q));

    // R1: during reset every entry holds zero
    p_reset_clear_r1: assert property (@(posedge clk)
        (!rst_n) |-> (q == '0));

endmodule

// File: rtl/rfb_read_port.sv
module rfb_read_port
    import rfb_pkg::*;
#(
    parameter int unsigned DATA_W = RFB_DATA_W,
    parameter int unsigned ADDR_W = RFB_ADDR_W,
    localparam int unsigned DEPTH = 1 << ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DEPTH-1:0][DATA_W-1:0]  q,
    input  logic [ADDR_W-1:0]             rd_addr,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DATA_W-1:0]             rd_data
);

    logic              addr_live;
    logic              bypass_hit;
    logic [DATA_W-1:0] stored;

    assign addr_live  = (rd_addr != ADDR_W'(RFB_ZERO_IDX));
    assign bypass_hit = wr_en && addr_live && (wr_addr == rd_addr);
    assign stored     = q[rd_addr];

    always_comb begin
        if (bypass_hit) begin
            rd_data = wr_data;
        end else begin
            rd_data = stored;
        end
    end

    // R4: data forwarded during a collision is exactly what the array commits
    p_bypass_commits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_addr != '0 && wr_addr == rd_addr)
            |=> (q[$past(rd_addr)] == $past(rd_data)));

    // R5: with no write pending, the value read is the value that stays stored
    p_idle_reads_stored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> (q[$past(rd_addr)] == $past(rd_data)));

endmodule

// File: rtl/rfb_regfile.sv
module rfb_regfile
    import rfb_pkg::*;
#(
    parameter int unsigned DATA_W = RFB_DATA_W,
    parameter int unsigned ADDR_W = RFB_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);

    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned NPORT = RFB_RD_PORTS;

    logic [DEPTH-1:0][DATA_W-1:0] q;
    logic [NPORT-1:0][ADDR_W-1:0] port_addr;
    logic [NPORT-1:0][DATA_W-1:0] port_data;

    assign port_addr[0] = rd_addr_a;
    assign port_addr[1] = rd_addr_b;
    assign rd_data_a    = port_data[0];
    assign rd_data_b    = port_data[1];

    rfb_storage #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_storage (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .q       (q)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        rfb_read_port #(
            .DATA_W (DATA_W),
            .ADDR_W (ADDR_W)
        ) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .q       (q),
            .rd_addr (port_addr[p]),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_data (port_data[p])
        );
    end

    // R6: port A never returns anything but zero for address 0
    p_zero_read_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    // R6: port B never returns anything but zero for address 0
    p_zero_read_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    // R7: two ports aimed at the same register agree
    p_ports_agree_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b));

endmodule

// File: tb/rfb_regfile_bench.sv
module rfb_regfile_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_addr_a = '0;
    logic [4:0]  rd_addr_b = '0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic [31:0] rd_data_a;
    logic [31:0] rd_data_b;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    rfb_regfile u_rfb_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_a (rd_addr_a),
        .rd_addr_b (rd_addr_b),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_en     (wr_en),
        .rd_data_a (rd_data_a),
        .rd_data_b (rd_data_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural expectation: zero register, same-cycle write wins, else stored.
    function automatic logic [31:0] expect_rd(input logic [4:0] a);
        if (a == 0) return 32'h0;
        if (wr_en && wr_addr == a) return wr_data;
        return model[a];
    endfunction

    // One cycle: drive after the falling edge, compare, then commit in the model.
    task automatic step(input string req, input logic [4:0] ra, input logic [4:0] rb,
                        input logic [4:0] wa, input logic [31:0] wd, input logic we);
        @(negedge clk);
        rd_addr_a = ra;
        rd_addr_b = rb;
        wr_addr   = wa;
        wr_data   = wd;
        wr_en     = we;
        #1;
        check(req, rd_data_a, expect_rd(ra));
        check(req, rd_data_b, expect_rd(rb));
        @(posedge clk);
        if (rst_n && we && wa != 0) model[wa] = wd;
    endtask

    task automatic clear_model();
        for (int i = 0; i < 32; i++) model[i] = 32'h0;
    endtask

    initial begin
        clear_model();
        repeat (3) @(posedge clk);
        // R1: contents are zero while reset is held
        @(negedge clk);
        rd_addr_a = 5'd9;
        rd_addr_b = 5'd31;
        #1;
        check("R1", rd_data_a, 32'h0);
        check("R1", rd_data_b, 32'h0);
        rst_n = 1'b1;

        // R1: every register reads zero after reset
        for (int i = 0; i < 32; i++) step("R1", 5'(i), 5'(31 - i), 5'd0, 32'h0, 1'b0);

        // R2: writes land on the edge and read back afterwards
        for (int i = 1; i < 32; i++) step("R2", 5'd0, 5'd0, 5'(i), 32'h1000_0000 + 32'(i) * 32'h0101, 1'b1);
        for (int i = 0; i < 32; i++) step("R2", 5'(i), 5'(31 - i), 5'd0, 32'h0, 1'b0);

        // R3: disabled writes leave contents untouched
        step("R3", 5'd3, 5'd4, 5'd3, 32'hDEAD_BEEF, 1'b0);
        step("R3", 5'd3, 5'd4, 5'd4, 32'hDEAD_BEEF, 1'b0);
        step("R3", 5'd3, 5'd4, 5'd0, 32'h0, 1'b0);

        // R5: collision with write disabled reads the stored value
        step("R5", 5'd7, 5'd7, 5'd7, 32'h5555_AAAA, 1'b0);
        step("R5", 5'd7, 5'd2, 5'd0, 32'h0, 1'b0);

        // R4: same-cycle bypass on port A, then on port B, then confirm commit
        step("R4", 5'd5, 5'd6, 5'd5, 32'hA5A5_0005, 1'b1);
        step("R4", 5'd5, 5'd6, 5'd6, 32'h5A5A_0006, 1'b1);
        step("R4", 5'd5, 5'd6, 5'd0, 32'h0, 1'b0);

        // R7: both ports on one register with bypass, then differing registers
        step("R7", 5'd20, 5'd20, 5'd20, 32'h7777_0020, 1'b1);
        step("R7", 5'd20, 5'd21, 5'd21, 32'h7777_0021, 1'b1);
        step("R7", 5'd21, 5'd20, 5'd0, 32'h0, 1'b0);

        // R6: writes to register 0 ignored and never forwarded
        step("R6", 5'd0, 5'd0, 5'd0, 32'hFFFF_FFFF, 1'b1);
        step("R6", 5'd0, 5'd1, 5'd0, 32'h1234_5678, 1'b1);
        step("R6", 5'd0, 5'd0, 5'd0, 32'h0, 1'b0);

        // R8: load writes reg 8 in write-back while a later add reads reg 8 in decode
        step("R8", 5'd9, 5'd0, 5'd8, 32'h0BAD_0008, 1'b1);
        step("R8", 5'd11, 5'd12, 5'd10, 32'h0000_0A0A, 1'b1);
        step("R8", 5'd11, 5'd12, 5'd10, 32'h0000_0B0B, 1'b1);
        step("R8", 5'd8, 5'd12, 5'd8, 32'hC0DE_F00D, 1'b1);
        step("R8", 5'd8, 5'd10, 5'd0, 32'h0, 1'b0);

        // R7: random run over a narrow range so collisions are frequent
        for (int n = 0; n < 600; n++) begin
            step("R7", 5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
                 5'($urandom_range(0, 7)), $urandom, 1'($urandom_range(0, 1)));
        end

        // R1: a second reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        @(posedge clk);
        clear_model();
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) step("R1", 5'(i), 5'(i + 8), 5'd0, 32'h0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule